// File: doc/BRIEF.md
# Indirect Lookup-Memory Access Window

This block gives a host access to a set of internal lookup memories, such as correction tables, tone curves and sharpening tables, through three write-only registers and one read-only register instead of a full memory map. The host first writes a mode word. The mode word picks one of the memory banks, the direction of the access, whether the address advances on its own, and a host/external ownership bit. Next the host writes a start address. After that, every write to the data register performs one access on the selected bank at the current internal pointer.

In write direction, a data-register write stores the value and also returns the word that was overwritten, so one access both reads and writes. In read direction, the value written is a dummy and only starts a fetch. The fetched word appears in the read-data register one cycle later, while a busy flag covers that latency. With auto-increment set, a block transfer needs one address write and then a stream of data writes. The pointer wraps to zero at the end of the selected bank.

The banks are single-port RAMs held inside the block. Bank `i` holds `2**(BASE_AW-i)` words.

Top module: `lut_window`

## Requirements
- R1: While reset is held and just after it is released, `rdData` is 0 and `busy` is 0. The mode word, the address register and the pointer also reset to 0.
- R2: `regSel` picks the register: 0 is the mode word, 1 is the address, 2 is data, and 3 is ignored. The mode word is decoded from `regWrData` as follows: bits [SEL_W-1:0] are the bank select, bit SEL_W is the direction (1 = write, 0 = read), bit SEL_W+1 is auto-increment, and bit SEL_W+2 is the external bit.
- R3: In write direction, a data-register write stores `regWrData` in the selected bank at the current pointer.
- R4: A data-register write that is accepted sets `busy` for exactly one cycle. `rdData` is updated only at the clock edge that ends that busy cycle, and it is never updated at any other time.
- R5: In read direction, the write data is ignored, and `rdData` becomes the word stored at the pointer. In write direction, `rdData` becomes the word held before the store (write after read).
- R6: When auto-increment is set, the pointer advances by one after each accepted access. When it is clear, the pointer stays where it is.
- R7: A write of the address register loads the pointer from that value. A write of the mode word reloads the pointer from the stored address register. In both cases the value is taken modulo the depth of the selected bank.
- R8: Bank `i` has depth `2**(BASE_AW-i)`. Auto-increment wraps the pointer from depth-1 to 0.
- R9: A bank select of NUM_MEMS or above leaves every bank unchanged, and the access returns 0 in `rdData`.
- R10: When the external bit is 1, data-register writes are ignored. `busy` stays 0, and neither `rdData`, the memories nor the pointer change.
- R11: Any register write that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 2 | Register select (0 mode, 1 address, 2 data) |
| regWrData | input | DATA_W | Host write value |
| rdData | output | DATA_W | Read-data register |
| busy | output | 1 | Access in flight; `rdData` is valid once this clears |

## Verification
The bench builds the block with its defaults: four banks of 64, 32, 16 and 8 words, a 3-bit select and 16-bit data. With the 8-word bank, the pointer wrap is reached after only a few accesses, and the 3-bit select leaves four unused codes for the unimplemented-bank case. Because every bank is filled before the random phase starts, each later write-after-read return can be predicted exactly.

// File: rtl/lut_window_pkg.sv
`timescale 1ns/1ps
package lut_window_pkg;

  typedef struct packed {
    logic access;   // perform one bank access this cycle
    logic write;    // the access also stores
    logic capture;  // move bank output into the read-data register
  } winStrobe_t;

  // number of words in bank sel; unimplemented selects behave as depth 1
  function automatic int unsigned memDepth(input int unsigned sel,
                                           input int unsigned numMems,
                                           input int unsigned baseAw);
    if (sel < numMems) return 32'd1 << (baseAw - sel);
    return 32'd1;
  endfunction

endpackage

// File: rtl/lut_window_ctrl.sv
`timescale 1ns/1ps
module lut_window_ctrl #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned BASE_AW  = 6,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [1:0]                    regSel,
  input  logic [DATA_W-1:0]             regWrData,
  output lut_window_pkg::winStrobe_t    stb,
  output logic [SEL_W-1:0]              memSel,
  output logic [BASE_AW-1:0]            memAddr,
  output logic [DATA_W-1:0]             memData,
  output logic                          busy
);
  import lut_window_pkg::*;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam int unsigned DIR_BIT = SEL_W;
  localparam int unsigned INC_BIT = SEL_W + 1;
  localparam int unsigned EXT_BIT = SEL_W + 2;

  logic [SEL_W-1:0]   modeSel;
  logic               modeWrite, modeInc, modeExt;
  logic [BASE_AW-1:0] addrReg, ptr;
  logic               busyQ;
  logic               hostFree, modeHit, addrHit, doAccess;
  logic [SEL_W-1:0]   newSel;

  function automatic logic [BASE_AW-1:0] ptrMask(input logic [SEL_W-1:0] s);
    int unsigned d;
    d = memDepth(int'(s), NUM_MEMS, BASE_AW);
    return BASE_AW'(d - 1);
  endfunction

  always_comb begin
    hostFree = regWrEn && !busyQ;
    modeHit  = hostFree && (regSel == REG_MODE);
    addrHit  = hostFree && (regSel == REG_ADDR);
    doAccess = hostFree && (regSel == REG_DATA) && !modeExt;
    newSel   = regWrData[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel   <= '0;
      modeWrite <= 1'b0;
      modeInc   <= 1'b0;
      modeExt   <= 1'b0;
      addrReg   <= '0;
      ptr       <= '0;
      busyQ     <= 1'b0;
    end else begin
      busyQ <= doAccess;
      if (modeHit) begin
        modeSel   <= newSel;
        modeWrite <= regWrData[DIR_BIT];
        modeInc   <= regWrData[INC_BIT];
        modeExt   <= regWrData[EXT_BIT];
        ptr       <= addrReg & ptrMask(newSel);
      end else if (addrHit) begin
        addrReg <= regWrData[BASE_AW-1:0];
        ptr     <= regWrData[BASE_AW-1:0] & ptrMask(modeSel);
      end else if (doAccess && modeInc) begin
        ptr <= (ptr + 1'b1) & ptrMask(modeSel);
      end
    end
  end

  always_comb begin
    stb.access  = doAccess;
    stb.write   = modeWrite;
    stb.capture = busyQ;
    memSel      = modeSel;
    memAddr     = ptr;
    memData     = regWrData;
    busy        = busyQ;
  end

endmodule

// File: rtl/lut_window_dp.sv
`timescale 1ns/1ps
module lut_window_dp #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned BASE_AW  = 6,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lut_window_pkg::winStrobe_t stb,
  input  logic [SEL_W-1:0]           memSel,
  input  logic [BASE_AW-1:0]         memAddr,
  input  logic [DATA_W-1:0]          memData,
  output logic [DATA_W-1:0]          rdData
);
  import lut_window_pkg::*;

  logic [NUM_MEMS-1:0][DATA_W-1:0] bankOut;
  logic [SEL_W-1:0]                lastSel;
  logic [DATA_W-1:0]               selOut;

  for (genvar i = 0; i < NUM_MEMS; i++) begin : g_bank
    localparam int unsigned AW_I  = BASE_AW - i;
    localparam int unsigned DEPTH = memDepth(i, NUM_MEMS, BASE_AW);
    logic [DATA_W-1:0] ram [DEPTH];
    logic [DATA_W-1:0] q;
    logic [AW_I-1:0]   idx;
    logic              hit;

    always_comb begin
      idx = memAddr[AW_I-1:0];
      hit = stb.access && (memSel == SEL_W'(i));
    end

    // single port, read-before-write
    always_ff @(posedge clk) begin
      if (hit) begin
        q <= ram[idx];
        if (stb.write) ram[idx] <= memData;
      end
    end

    assign bankOut[i] = q;
  end

  always_comb begin
    selOut = '0;
    for (int i = 0; i < NUM_MEMS; i++) begin
      if (lastSel == SEL_W'(i)) selOut = bankOut[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSel <= '0;
      rdData  <= '0;
    end else begin
      if (stb.access) lastSel <= memSel;
      if (stb.capture) rdData <= selOut;
    end
  end

endmodule

// File: rtl/lut_window.sv
`timescale 1ns/1ps
module lut_window #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned BASE_AW  = 6,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  import lut_window_pkg::*;

  winStrobe_t         stb;
  logic [SEL_W-1:0]   memSel;
  logic [BASE_AW-1:0] memAddr;
  logic [DATA_W-1:0]  memData;

  lut_window_ctrl #(
    .NUM_MEMS(NUM_MEMS), .BASE_AW(BASE_AW), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .stb(stb), .memSel(memSel), .memAddr(memAddr),
    .memData(memData), .busy(busy)
  );

  lut_window_dp #(
    .NUM_MEMS(NUM_MEMS), .BASE_AW(BASE_AW), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memSel(memSel), .memAddr(memAddr),
    .memData(memData), .rdData(rdData)
  );

endmodule

// File: rtl/lut_window_chk.sv
`timescale 1ns/1ps
module lut_window_chk #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned BASE_AW  = 6,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DATA_W   = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busy,
  input logic [DATA_W-1:0]          rdData,
  input lut_window_pkg::winStrobe_t stb,
  input logic [SEL_W-1:0]           memSel,
  input logic [BASE_AW-1:0]         memAddr
);
  import lut_window_pkg::*;

  a_r4_busy_after_access: assert property (@(posedge clk) disable iff (!rstN)
    stb.access |=> busy);

  a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  a_r4_rd_only_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(rdData));

  a_r11_no_access_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.access);

  a_r8_ptr_in_depth: assert property (@(posedge clk) disable iff (!rstN)
    stb.access |-> (int'(memAddr) < int'(memDepth(int'(memSel), NUM_MEMS, BASE_AW))));

  a_r9_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.access && (int'(memSel) >= int'(NUM_MEMS))) |=> ##1 (rdData == '0));

endmodule

bind lut_window lut_window_chk #(
  .NUM_MEMS(NUM_MEMS), .BASE_AW(BASE_AW), .SEL_W(SEL_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .rdData(rdData), .stb(stb),
  .memSel(memSel), .memAddr(memAddr)
);

// File: tb/test_lut_window.sv
`timescale 1ns/1ps
module test_lut_window;
  localparam int NM = 4;
  localparam int BA = 6;
  localparam int SW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] rdData;
  logic          busy;

  lut_window i_lut_window (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .rdData(rdData), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state
  int  mem   [NM][64];
  bit  known [NM][64];
  int  mSel = 0, mAddr = 0, mPtr = 0;
  bit  mDir = 0, mInc = 0, mExt = 0;
  int  expRd = 0;

  function automatic int depthOf(int s);
    return (s < NM) ? (64 >> s) : 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [1:0] s, logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // R2 mode word: {ext, inc, dir, sel[2:0]}
  task automatic setMode(int s, bit dir, bit inc, bit ext);
    pulse(2'd0, DW'({ext, inc, dir, 3'(s)}));
    mSel = s; mDir = dir; mInc = inc; mExt = ext;
    mPtr = mAddr % depthOf(mSel);
  endtask

  task automatic setAddr(int a);
    pulse(2'd1, DW'(a));
    mAddr = a % 64;
    mPtr  = mAddr % depthOf(mSel);
  endtask

  task automatic access(int d, string req);
    bit acc, chkRd;
    acc = !mExt;
    chkRd = 1;
    if (acc) begin
      if (mSel < NM) begin
        chkRd = known[mSel][mPtr];
        expRd = mem[mSel][mPtr];
        if (mDir) begin mem[mSel][mPtr] = d; known[mSel][mPtr] = 1; end
      end else expRd = 0;
      if (mInc) mPtr = (mPtr + 1) % depthOf(mSel);
    end
    pulse(2'd2, DW'(d));
    chk({req, " busy"}, int'(busy), int'(acc));
    @(negedge clk);
    chk({req, " busy clear"}, int'(busy), 0);
    if (chkRd) chk({req, " rdData"}, int'(rdData), expRd);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 rdData in reset", int'(rdData), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData after reset", int'(rdData), 0);
    chk("R1 busy after reset", int'(busy), 0);

    // R3 R6: fill each bank with auto-increment writes
    for (int b = 0; b < NM; b++) begin
      setMode(b, 1, 1, 0);
      setAddr(0);
      for (int k = 0; k < depthOf(b); k++) access(int'($urandom & 16'hFFFF), "R3 fill");
    end

    // R5 R8: read back with wrap through the end of each bank
    for (int b = 0; b < NM; b++) begin
      setMode(b, 0, 1, 0);
      setAddr(depthOf(b) - 2);
      for (int k = 0; k < 4; k++) access(int'($urandom & 16'hFFFF), "R8 wrap read");
    end

    // R5 write after read
    setMode(3, 1, 0, 0);
    setAddr(5);
    access(16'h1234, "R5 write after read");
    access(16'h5678, "R5 old value returned");

    // R6 no increment: repeat the same location
    setMode(3, 0, 0, 0);
    access(0, "R6 no increment");
    access(0, "R6 no increment again");

    // R7 mode write reloads the pointer from the address register
    setAddr(40);
    setMode(2, 0, 1, 0);
    access(0, "R7 reload modulo depth");

    // R9 unimplemented banks
    setMode(5, 1, 1, 0);
    access(16'hBEEF, "R9 unimplemented");
    setMode(7, 0, 0, 0);
    access(0, "R9 unimplemented read");

    // R10 external bit blocks access
    setMode(1, 1, 1, 0);
    setAddr(3);
    access(16'hAAAA, "R10 setup");
    setMode(1, 1, 1, 1);
    access(16'h5555, "R10 ignored");
    chk("R10 rdData kept", int'(rdData), 16'hAAAA & 0 | expRd);
    setMode(1, 0, 0, 0);
    setAddr(3);
    access(0, "R10 memory unchanged");

    // R11 back-to-back data writes: second is ignored
    setMode(0, 1, 1, 0);
    setAddr(10);
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd2; regWrData = 16'h0F0F;
    expRd = mem[0][10]; mem[0][10] = 16'h0F0F; mPtr = 11;
    @(negedge clk);
    regWrData = 16'hF0F0;
    chk("R11 busy", int'(busy), 1);
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R11 rdData first", int'(rdData), expRd);
    chk("R11 busy clear", int'(busy), 0);
    setMode(0, 0, 1, 0);
    setAddr(10);
    access(0, "R11 only first stored");
    access(0, "R11 next untouched");

    // R2 register select 3 is ignored
    pulse(2'd3, 16'hFFFF);
    access(0, "R2 select 3 ignored");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      if (op == 0) begin
        int s;
        s = int'($urandom % 5);
        if (s == 4) s = 4 + int'($urandom % 4);
        setMode(s, bit'($urandom % 2), bit'($urandom % 2), ($urandom % 8) == 0);
      end else if (op == 1) begin
        setAddr(int'($urandom % 64));
      end else begin
        access(int'($urandom & 16'hFFFF), "R5 random");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule